// File: doc/BRIEF.md
# MASH Fractional-N Divide Controller

This block sets the feedback divide ratio of a fractional-N synthesizer. On each rising edge of the comparison clock it emits a 13-bit divide value. That value is a fixed integer ratio plus a small signed correction. A cascade of 18-bit accumulators produces the correction, and a differencing network combines their carries. Averaged over time, the correction equals the programmed fraction of one count, while its short-term error is pushed toward high offset frequencies.

The integer ratio is built from a 9-bit coarse count and a 4-bit fine count. The fraction is an 18-bit word. A run-time input selects the noise shaping: a second-order loop using two stages, or a third-order loop using three stages. A dither option alternates the first-stage addend between the fraction and the fraction plus one. This acts as a half-weight bit below the fraction's LSB, which doubles the fractional resolution. The integer ratio and the correction wrap modulo 2^13. The prescaler, the RF counters and the analog loop are outside this block.

Top module: `mash_divctl`

## Requirements
- R1: While `rst_n` is low, `div_ratio` is 0 and all accumulator, delay and toggle state is cleared. The reset is asynchronous on assertion. Its release is synchronised, so `div_ratio` stays 0 through the first two rising edges after `rst_n` rises.
- R2: The integer ratio is `{coarse_cnt, fine_cnt}`, with the coarse count in bits 12:4 and the fine count in bits 3:0. When `frac_word` is 0 and dither is off, every output equals this value exactly.
- R3: With `order2_sel` = 1, only two stages run and the correction is c1 + c2 − c2(n−1). Each output then differs from the integer ratio by −1, 0, +1 or +2.
- R4: With `order2_sel` = 0, a third stage is added and the correction is c1 + c2 − c2(n−1) + c3 − 2·c3(n−1) + c3(n−2). The per-cycle offset stays within −3..+4. For a fraction near one third, offsets outside −1..+2 do occur.
- R5: Starting from reset, the offsets summed over n outputs equal the stage-1 carry count floor(S/2^18) plus a residue. S is the total stage-1 addend. The residue is 0..+1 in second order and −1..+2 in third order. The mean therefore tends to the integer ratio plus K/2^18.
- R6: With `lsb_dither_en` = 1, the stage-1 addend is K on the first cycle after reset and K+1 on the next, alternating thereafter. This adds 1/2^19 to the mean. With K = 0, the output therefore leaves the integer ratio within 4096 cycles.
- R7: The first output after reset release equals the integer ratio, because all stages start from zero.
- R8: The sum of the integer ratio and the correction wraps modulo 2^13 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparison clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| order2_sel | input | 1 | 1 = second-order (two stages), 0 = third-order (three stages) |
| lsb_dither_en | input | 1 | 1 = alternate an extra half-LSB into the fraction |
| frac_word | input | 18 | Fractional word K |
| coarse_cnt | input | 9 | Upper part of the integer ratio |
| fine_cnt | input | 4 | Lower part of the integer ratio |
| div_ratio | output | 13 | Registered instantaneous divide value |

## Verification
Each stimulus vector fixes the order, the dither, the fraction and the integer ratio, then collects 4096 outputs from reset. A zero fraction separates exact integer pass-through from any leakage in the accumulators. Half and one-third fractions tell the two noise-shaping orders apart by the span of offsets they produce, and the summed offset against the carry-count bound exposes wrong carry weights or differencing signs. Integer ratios of 8191 and 0 force the modulo wrap upward and downward, and dither with a zero fraction shows the hidden half-LSB on its own.

// File: rtl/mash_divctl_pkg.sv
`timescale 1ns/1ps
package mash_divctl_pkg;
  localparam int FRAC_W      = 18;
  localparam int COARSE_W    = 9;
  localparam int FINE_W      = 4;
  localparam int OFS_W       = 4;
  localparam int MASH_STAGES = 3;
endpackage

// File: rtl/mash_acc_stage.sv
`timescale 1ns/1ps
module mash_acc_stage #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W:0]   addend,
  output logic         carry,
  output logic [W-1:0] resid
);
  logic [W-1:0] acc_q;
  logic [W-1:0] acc_d;
  logic [W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + addend;
    resid = sum[W-1:0];
    carry = en & sum[W];
    acc_d = en ? sum[W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/mash_shaper.sv
`timescale 1ns/1ps
module mash_shaper #(
  parameter int OFS_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    order3,
  input  logic [2:0]              carries,
  output logic signed [OFS_W-1:0] ofs
);
  logic c2_d1, c3_d1, c3_d2;
  logic [OFS_W-1:0] t1, t2, t3;

  always_comb begin
    t1 = OFS_W'(carries[0]);
    t2 = OFS_W'(carries[1]) - OFS_W'(c2_d1);
    t3 = order3 ? (OFS_W'(carries[2]) - OFS_W'({c3_d1, 1'b0}) + OFS_W'(c3_d2)) : '0;
    ofs = $signed(t1 + t2 + t3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_d1 <= 1'b0;
      c3_d1 <= 1'b0;
      c3_d2 <= 1'b0;
    end else begin
      c2_d1 <= carries[1];
      c3_d1 <= carries[2];
      c3_d2 <= c3_d1;
    end
  end

  assert_order2_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !order3 |-> (ofs >= -2'sd1 && ofs <= 3'sd2));
  assert_order3_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    order3 |-> (ofs >= -3'sd3 && ofs <= 4'sd4));
endmodule

// File: rtl/mash_divctl.sv
`timescale 1ns/1ps
module mash_divctl
  import mash_divctl_pkg::*;
#(
  parameter int P_FRAC_W   = FRAC_W,
  parameter int P_COARSE_W = COARSE_W,
  parameter int P_FINE_W   = FINE_W,
  parameter int P_OFS_W    = OFS_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              order2_sel,
  input  logic                              lsb_dither_en,
  input  logic [P_FRAC_W-1:0]               frac_word,
  input  logic [P_COARSE_W-1:0]             coarse_cnt,
  input  logic [P_FINE_W-1:0]               fine_cnt,
  output logic [P_COARSE_W+P_FINE_W-1:0]    div_ratio
);
  localparam int INT_W = P_COARSE_W + P_FINE_W;
  localparam int NST   = MASH_STAGES;

  logic                      rst_meta, rst_sync_n;
  logic                      tgl_q, tgl_d;
  logic [P_FRAC_W:0]         addend [NST];
  logic [P_FRAC_W-1:0]       resid  [NST];
  logic [NST-1:0]            carry;
  logic [NST-1:0]            st_en;
  logic signed [P_OFS_W-1:0] ofs;
  logic [INT_W-1:0]          int_value;
  logic [INT_W-1:0]          div_d;

  // reset: asynchronous assert, two-flop synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // half-LSB toggle
  always_comb tgl_d = lsb_dither_en ? ~tgl_q : 1'b0;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) tgl_q <= 1'b0;
    else             tgl_q <= tgl_d;
  end

  for (genvar g = 0; g < NST; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign addend[g] = {1'b0, frac_word} + {{P_FRAC_W{1'b0}}, lsb_dither_en & tgl_q};
    end else begin : g_next
      assign addend[g] = {1'b0, resid[g-1]};
    end
    if (g < 2) begin : g_always
      assign st_en[g] = 1'b1;
    end else begin : g_order3
      assign st_en[g] = ~order2_sel;
    end
    mash_acc_stage #(.W(P_FRAC_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .en     (st_en[g]),
      .addend (addend[g]),
      .carry  (carry[g]),
      .resid  (resid[g])
    );
  end

  mash_shaper #(.OFS_W(P_OFS_W)) u_shaper (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .order3  (~order2_sel),
    .carries (carry),
    .ofs     (ofs)
  );

  always_comb begin
    int_value = {coarse_cnt, fine_cnt};
    div_d     = int_value + {{(INT_W-P_OFS_W){ofs[P_OFS_W-1]}}, ofs};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) div_ratio <= '0;
    else             div_ratio <= div_d;
  end

  always @(posedge clk) begin
    if (rst_sync_n == 1'b0) assert_reset_clear_R1: assert (div_ratio == '0);
  end

  assert_int_path_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ofs == '0) |=> (div_ratio == $past(int_value)));

  assert_dither_alt_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lsb_dither_en && $past(lsb_dither_en) && $past(rst_sync_n)) |-> (tgl_q != $past(tgl_q)));

  assert_stage3_idle_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (order2_sel && $past(order2_sel)) |-> (resid[NST-1] == resid[NST-2] && carry[NST-1] == 1'b0));
endmodule

// File: tb/mash_divctl_bench.sv
`timescale 1ns/1ps
module mash_divctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 4096;
  localparam int NV         = 9;

  typedef struct packed {
    logic        o2;
    logic        dith;
    logic [17:0] k;
    logic [8:0]  co;
    logic [3:0]  fi;
    logic        wide_chk;
    logic        wrap_chk;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 18'd0,      9'd100, 4'd5,  1'b0, 1'b0},
    '{1'b0, 1'b0, 18'd0,      9'd37,  4'd9,  1'b0, 1'b0},
    '{1'b1, 1'b0, 18'd131072, 9'd200, 4'd3,  1'b0, 1'b0},
    '{1'b0, 1'b0, 18'd131072, 9'd200, 4'd3,  1'b0, 1'b0},
    '{1'b0, 1'b0, 18'd87381,  9'd50,  4'd0,  1'b1, 1'b0},
    '{1'b1, 1'b0, 18'd262143, 9'd511, 4'd15, 1'b0, 1'b1},
    '{1'b0, 1'b0, 18'd87381,  9'd0,   4'd0,  1'b0, 1'b1},
    '{1'b0, 1'b1, 18'd0,      9'd12,  4'd12, 1'b0, 1'b0},
    '{1'b1, 1'b1, 18'd77777,  9'd300, 4'd7,  1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        order2_sel = 1'b1;
  logic        lsb_dither_en = 1'b0;
  logic [17:0] frac_word = '0;
  logic [8:0]  coarse_cnt = '0;
  logic [3:0]  fine_cnt = '0;
  logic [12:0] div_ratio;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mash_divctl u_mash_divctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .order2_sel    (order2_sel),
    .lsb_dither_en (lsb_dither_en),
    .frac_word     (frac_word),
    .coarse_cnt    (coarse_cnt),
    .fine_cnt      (fine_cnt),
    .div_ratio     (div_ratio)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wrap_diff(input int out, input int base);
    int d = ((out - base) % 8192 + 8192) % 8192;
    if (d >= 4096) d -= 8192;
    return d;
  endfunction

  task automatic start_run(input vec_t v);
    rst_n = 1'b0;
    order2_sel = v.o2;
    lsb_dither_en = v.dith;
    frac_word = v.k;
    coarse_cnt = v.co;
    fine_cnt = v.fi;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(div_ratio == 13'd0, "R1 in reset", div_ratio, 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(div_ratio == 13'd0, "R1 release edge 1", div_ratio, 0);
    @(posedge clk);
    @(negedge clk);
    check(div_ratio == 13'd0, "R1 release edge 2", div_ratio, 0);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int nint, d, sum, lo, hi, bad, nonzero, wide, wraps, first_d;
    longint tot, c1sum;
    start_run(v);
    nint = int'({v.co, v.fi});
    sum = 0; bad = 0; nonzero = 0; wide = 0; wraps = 0; first_d = 0;
    for (int i = 0; i < WIN; i++) begin
      @(posedge clk);
      @(negedge clk);
      d = wrap_diff(int'(div_ratio), nint);
      if (i == 0) first_d = d;
      sum += d;
      if (d != 0) nonzero++;
      if (d < -1 || d > 2) wide++;
      if (v.o2 ? (d < -1 || d > 2) : (d < -3 || d > 4)) bad++;
      if ((d > 0 && int'(div_ratio) < nint) || (d < 0 && int'(div_ratio) > nint)) wraps++;
    end
    tot = longint'(WIN) * longint'(v.k) + (v.dith ? longint'(WIN / 2) : 64'sd0);
    c1sum = tot >>> 18;
    lo = int'(c1sum) + (v.o2 ? 0 : -1);
    hi = int'(c1sum) + (v.o2 ? 1 : 2);
    $display("[TB] vector %0d: offset sum %0d, bound %0d..%0d", idx, sum, lo, hi);
    check(first_d == 0, "R7 first output", first_d, 0);
    if (v.o2) check(bad == 0, "R3 range -1..2 violations", bad, 0);
    else      check(bad == 0, "R4 range -3..4 violations", bad, 0);
    check(sum >= lo && sum <= hi, "R5 offset sum", sum, c1sum);
    if (v.k == 0 && !v.dith) check(nonzero == 0, "R2 exact integer cycles off", nonzero, 0);
    if (v.k == 0 && v.dith)  check(nonzero > 0, "R6 dither visible", nonzero, 1);
    if (v.wide_chk)          check(wide > 0, "R4 third-order span", wide, 1);
    if (v.wrap_chk)          check(wraps > 0, "R8 modulo wrap seen", wraps, 1);
  endtask

  initial begin
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R1: reset asserted mid-run clears output asynchronously
    start_run(VECS[3]);
    repeat (50) @(posedge clk);
    @(negedge clk);
    check(div_ratio != 13'd0, "R1 running output nonzero", div_ratio, 1);
    #1 rst_n = 1'b0;
    #1 check(div_ratio == 13'd0, "R1 async clear", div_ratio, 0);

    // R2: integer field placement, coarse in 12:4 and fine in 3:0
    start_run('{1'b1, 1'b0, 18'd0, 9'h155, 4'hA, 1'b0, 1'b0});
    @(posedge clk);
    @(negedge clk);
    check(div_ratio == 13'h155A, "R2 field placement", div_ratio, 13'h155A);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule